// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block decides, one ADC clock at a time, which of three color inputs (red, green or blue) the analog multiplexer presents to the converter. It supports three modes. In three-channel mode it cycles through all three colors in a fixed direction. In two-channel mode it alternates between any two enabled colors. In single-channel mode it stays on one color. A rising edge on a line-restart input returns the three-channel cycle to its first color. Every sample leaves the block with a channel tag, so the output formatter can label the words it emits.

For the alternate output format family, the block also produces an internal sampling pulse. It derives this pulse from an external sample-pulse input. A select bit picks the rising or the falling edge of that input, and a 3-bit code delays the pulse by 1 to 8 clocks. The register bank supplies the mode, order, select, edge and delay fields as static levels. One clock cycle equals one ADC sample slot, and the `adv` input marks the slots in which a sample is taken.

Top module: `chan_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets. After that edge, `ch_idx` is 0 (red), `tag_valid` is 0 and `int_pulse` is 0.
- R2: With `mode3`=1 and `order_fwd`=1, each clock with `adv`=1 steps `ch_idx` through 0, 1, 2, 0 (red, green, blue). Channel codes are 0 red, 1 green, 2 blue, and `ch_idx` never shows 3.
- R3: With `mode3`=1 and `order_fwd`=0, each clock with `adv`=1 steps `ch_idx` through 2, 1, 0, 2 (blue, green, red).
- R4: With `mode3`=1, a clock at which `restart_in` is high after being low on the previous clock loads the first channel of the order into `ch_idx`: 0 if `order_fwd`=1, 2 if `order_fwd`=0. This happens whatever the value of `adv`. Holding `restart_in` high gives no further restart. With `mode3`=0, `restart_in` has no effect.
- R5: A clock with `adv`=0 and no restart from R4 leaves `ch_idx` unchanged.
- R6: With `mode3`=0 and exactly one bit of `chan_sel` set (bit 0 red, bit 1 green, bit 2 blue), a clock with `adv`=1 sets `ch_idx` to that bit's channel, and it stays there.
- R7: With `mode3`=0 and exactly two bits of `chan_sel` set, the pair's first channel is the lower code when `order_fwd`=1 and the higher code when `order_fwd`=0. On a clock with `adv`=1, if `ch_idx` holds the first channel it moves to the second; in every other case it moves to the first.
- R8: With `mode3`=0 and zero or three bits of `chan_sel` set, a clock with `adv`=1 sets `ch_idx` to 0 (red).
- R9: After a clock with `adv`=1, `tag_valid` is 1 and `tag` equals the `ch_idx` held during that clock. After a clock with `adv`=0, `tag_valid` is 0.
- R10: With `alt_fmt`=1, suppose the clock edge at which `pulse_in` is first seen rising (`edge_pos`=1) or falling (`edge_pos`=0) is edge E. Then `int_pulse` is high for exactly the one cycle following the clock edge `dly_code` clocks after E. An edge of the other polarity produces no pulse.
- R11: Edges of `pulse_in` seen while `alt_fmt`=0 never produce `int_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC sample clock, one cycle per sample slot |
| rst_n | input | 1 | Synchronous reset, active low |
| adv | input | 1 | A sample is taken in this slot; step the sequence |
| restart_in | input | 1 | Line restart level; its rising edge restarts the three-channel order |
| mode3 | input | 1 | 1 selects three-channel mode |
| order_fwd | input | 1 | 1 gives red-green-blue order, 0 gives blue-green-red |
| chan_sel | input | 3 | Channel enables for one or two channel modes (bit 0 red, 1 green, 2 blue) |
| alt_fmt | input | 1 | Enables the internal sampling pulse generator |
| pulse_in | input | 1 | External sample-pulse input |
| edge_pos | input | 1 | 1 triggers on the rising edge of `pulse_in`, 0 on the falling edge |
| dly_code | input | 3 | Extra delay of the internal pulse, in clocks |
| ch_idx | output | 2 | Channel currently selected for the analog mux |
| tag_valid | output | 1 | `tag` carries the channel of the sample just taken |
| tag | output | 2 | Channel tag travelling with the sample |
| int_pulse | output | 1 | Internal sampling pulse, one cycle wide |

## Verification
`ch_idx` is registered, so it takes its new value one clock after the `adv` or restart edge that causes it. `tag` and `tag_valid` also follow `adv` by one clock, and they carry the channel that was held during that clock. `int_pulse` rises `dly_code`+1 clocks after the edge at which the transition of `pulse_in` is first sampled. The bench changes inputs just after a falling clock edge and samples outputs at the next falling edge. For each pulse case it counts clocks from the edge that sees the transition, so every result is read in the cycle it is due. A window longer than the deepest delay confirms that no stray pulse appears.

// File: rtl/chan_seq_pkg.sv
// Shared types and helpers for the channel sampling sequencer.
// Assumes three color channels coded red=0, green=1, blue=2.
package chan_seq_pkg;

    localparam int CH_W   = 2;
    localparam int NUM_CH = 3;

    typedef enum logic [CH_W-1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    // Step one position along the three-channel ring in the chosen direction.
    function automatic chan_e ring_step(input chan_e cur, input logic fwd);
        chan_e nxt;
        if (fwd) begin
            case (cur)
                CH_RED:  nxt = CH_GRN;
                CH_GRN:  nxt = CH_BLU;
                default: nxt = CH_RED;
            endcase
        end else begin
            case (cur)
                CH_BLU:  nxt = CH_GRN;
                CH_GRN:  nxt = CH_RED;
                default: nxt = CH_BLU;
            endcase
        end
        return nxt;
    endfunction

    // First channel of the ring for the chosen direction.
    function automatic chan_e ring_head(input logic fwd);
        return fwd ? CH_RED : CH_BLU;
    endfunction

endpackage

// File: rtl/chan_seq_edge.sv
// Single-edge detector on a level input.
// Assumes the input is already synchronous to clk; pol_rise picks the edge.
module chan_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic pol_rise,
    output logic ev
);

    logic sig_q;

    // Remember the level seen at the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // Flag the selected transition in the cycle it is first visible.
    always_comb begin
        ev = pol_rise ? (sig & ~sig_q) : (~sig & sig_q);
    end

endmodule

// File: rtl/chan_seq_fsm.sv
// Channel selection state: ring walk in three-channel mode, alternation of a
// pair in two-channel mode, a fixed channel in single-channel mode.
// Assumes configuration inputs are static levels from a register bank.
module chan_seq_fsm
    import chan_seq_pkg::*;
#(
    parameter int SEL_W = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              restart_ev,
    input  logic              mode3,
    input  logic              order_fwd,
    input  logic [SEL_W-1:0]  chan_sel,
    output logic [CH_W-1:0]   ch_idx
);

    localparam int CNT_W = $clog2(SEL_W + 1);

    chan_e            ch_q;
    chan_e            ch_nxt;
    chan_e            pair_lo;
    chan_e            pair_hi;
    chan_e            pair_first;
    chan_e            pair_second;
    chan_e            solo;
    logic [CNT_W-1:0] sel_cnt;

    // Count enabled channels.
    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < SEL_W; i++) begin
            sel_cnt = sel_cnt + CNT_W'(chan_sel[i]);
        end
    end

    // Decode the single channel and the two ends of a channel pair.
    always_comb begin
        solo        = chan_sel[0] ? CH_RED : (chan_sel[1] ? CH_GRN : CH_BLU);
        pair_lo     = chan_sel[0] ? CH_RED : CH_GRN;
        pair_hi     = chan_sel[2] ? CH_BLU : CH_GRN;
        pair_first  = order_fwd ? pair_lo : pair_hi;
        pair_second = order_fwd ? pair_hi : pair_lo;
    end

    // Choose the channel for the next sample slot.
    always_comb begin
        if (mode3) begin
            ch_nxt = ring_step(ch_q, order_fwd);
        end else begin
            case (sel_cnt)
                CNT_W'(1): ch_nxt = solo;
                CNT_W'(2): ch_nxt = (ch_q == pair_first) ? pair_second : pair_first;
                default:   ch_nxt = CH_RED;
            endcase
        end
    end

    // Hold, restart or advance the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ch_q <= CH_RED;
        else if (mode3 && restart_ev) ch_q <= ring_head(order_fwd);
        else if (adv)                 ch_q <= ch_nxt;
    end

    assign ch_idx = ch_q;

endmodule

// File: rtl/chan_seq_pulse.sv
// Internal sampling pulse generator: a shift line of trigger events tapped
// at a programmable depth. Assumes one trigger per edge of the input.
module chan_seq_pulse #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic [DLY_W-1:0] dly_code,
    output logic             int_pulse
);

    localparam int DEPTH = 1 << DLY_W;

    logic [DEPTH-1:0] line_q;

    // Shift accepted trigger events along the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= {line_q[DEPTH-2:0], enable & trig};
    end

    // Tap the line at the programmed depth.
    assign int_pulse = line_q[dly_code];

endmodule

// File: rtl/chan_seq.sv
// Top of the color channel sampling sequencer. It selects the mux channel per
// ADC slot, tags each sample with its channel and produces a delayed internal
// sampling pulse. Assumes all inputs are synchronous to clk.
module chan_seq
    import chan_seq_pkg::*;
#(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             restart_in,
    input  logic             mode3,
    input  logic             order_fwd,
    input  logic [2:0]       chan_sel,
    input  logic             alt_fmt,
    input  logic             pulse_in,
    input  logic             edge_pos,
    input  logic [DLY_W-1:0] dly_code,
    output logic [1:0]       ch_idx,
    output logic             tag_valid,
    output logic [1:0]       tag,
    output logic             int_pulse
);

    logic restart_ev;
    logic pulse_ev;

    chan_seq_edge u_restart_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (restart_in),
        .pol_rise (1'b1),
        .ev       (restart_ev)
    );

    chan_seq_fsm #(.SEL_W(NUM_CH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .restart_ev (restart_ev),
        .mode3      (mode3),
        .order_fwd  (order_fwd),
        .chan_sel   (chan_sel),
        .ch_idx     (ch_idx)
    );

    chan_seq_edge u_pulse_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (pulse_in),
        .pol_rise (edge_pos),
        .ev       (pulse_ev)
    );

    chan_seq_pulse #(.DLY_W(DLY_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (alt_fmt),
        .trig      (pulse_ev),
        .dly_code  (dly_code),
        .int_pulse (int_pulse)
    );

    // Capture the channel of each sample taken, for the output formatter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_valid <= 1'b0;
            tag       <= '0;
        end else begin
            tag_valid <= adv;
            if (adv) tag <= ch_idx;
        end
    end

endmodule

// File: rtl/chan_seq_chk.sv
// Property checker for chan_seq, attached by bind. It keeps its own record
// of the previous restart and pulse levels rather than reading the design's.
module chan_seq_chk #(
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             restart_in,
    input logic             mode3,
    input logic             order_fwd,
    input logic [2:0]       chan_sel,
    input logic             alt_fmt,
    input logic             pulse_in,
    input logic             edge_pos,
    input logic [DLY_W-1:0] dly_code,
    input logic [1:0]       ch_idx,
    input logic             tag_valid,
    input logic [1:0]       tag,
    input logic             int_pulse
);

    logic rs_q;
    logic pl_q;
    logic rs_rise;
    logic pl_trig;

    // Previous levels of the two edge-sensitive inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= 1'b0;
            pl_q <= 1'b0;
        end else begin
            rs_q <= restart_in;
            pl_q <= pulse_in;
        end
    end

    assign rs_rise = restart_in & ~rs_q;
    assign pl_trig = edge_pos ? (pulse_in & ~pl_q) : (~pulse_in & pl_q);

    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ch_idx != 2'd3);

    p_restart_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode3 && rs_rise) |=> (ch_idx == (order_fwd ? 2'd0 : 2'd2)));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !(mode3 && rs_rise)) |=> $stable(ch_idx));

    p_single_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode3 && adv && $countones(chan_sel) == 1) |=>
        (ch_idx == (chan_sel[1] ? 2'd1 : (chan_sel[2] ? 2'd2 : 2'd0))));

    p_default_red_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode3 && adv && ($countones(chan_sel) == 0 || $countones(chan_sel) == 3))
        |=> (ch_idx == 2'd0));

    p_tag_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tag_valid && tag == $past(ch_idx)));

    p_tag_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> !tag_valid);

    p_pulse_min_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_fmt && pl_trig && dly_code == '0) |=> int_pulse);

endmodule

bind chan_seq chan_seq_chk #(.DLY_W(DLY_W)) u_chan_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .restart_in (restart_in),
    .mode3      (mode3),
    .order_fwd  (order_fwd),
    .chan_sel   (chan_sel),
    .alt_fmt    (alt_fmt),
    .pulse_in   (pulse_in),
    .edge_pos   (edge_pos),
    .dly_code   (dly_code),
    .ch_idx     (ch_idx),
    .tag_valid  (tag_valid),
    .tag        (tag),
    .int_pulse  (int_pulse)
);

// File: tb/chan_seq_bench.sv
// Self-checking bench: sweeps every mode, order and select pattern with a
// mixed advance and restart pattern, then every delay code and edge choice.
module chan_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       adv;
    logic       restart_in;
    logic       mode3;
    logic       order_fwd;
    logic [2:0] chan_sel;
    logic       alt_fmt;
    logic       pulse_in;
    logic       edge_pos;
    logic [2:0] dly_code;
    logic [1:0] ch_idx;
    logic       tag_valid;
    logic [1:0] tag;
    logic       int_pulse;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int m_ch      = 0;
    bit m_rs_prev = 1'b0;

    always #4 clk = ~clk;

    chan_seq u_chan_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .restart_in (restart_in),
        .mode3      (mode3),
        .order_fwd  (order_fwd),
        .chan_sel   (chan_sel),
        .alt_fmt    (alt_fmt),
        .pulse_in   (pulse_in),
        .edge_pos   (edge_pos),
        .dly_code   (dly_code),
        .ch_idx     (ch_idx),
        .tag_valid  (tag_valid),
        .tag        (tag),
        .int_pulse  (int_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected next channel, worked out from R2, R3, R6, R7 and R8.
    function automatic int next_ch(input int cur, input bit m3, input bit fwd, input logic [2:0] s);
        int cnt = 0;
        int lo  = -1;
        int hi  = -1;
        int first;
        if (m3) return fwd ? (cur + 1) % 3 : (cur + 2) % 3;
        for (int i = 0; i < 3; i++) begin
            if (s[i]) begin
                cnt++;
                if (lo < 0) lo = i;
                hi = i;
            end
        end
        if (cnt == 1) return lo;
        if (cnt == 2) begin
            first = fwd ? lo : hi;
            return (cur == first) ? (fwd ? hi : lo) : first;
        end
        return 0;
    endfunction

    function automatic string mode_req(input bit m3, input bit fwd, input logic [2:0] s);
        int cnt = s[0] + s[1] + s[2];
        if (m3) return fwd ? "R2" : "R3";
        if (cnt == 1) return "R6";
        if (cnt == 2) return "R7";
        return "R8";
    endfunction

    // One sample slot: drive, predict, wait for the edge, compare.
    task automatic slot(input bit a, input bit rs);
        int    tag_exp = m_ch;
        bit    rise    = rs && !m_rs_prev;
        string lbl;
        adv        = a;
        restart_in = rs;
        if (mode3 && rise) begin
            m_ch = order_fwd ? 0 : 2;
            lbl  = "R4";
        end else if (a) begin
            m_ch = next_ch(m_ch, mode3, order_fwd, chan_sel);
            lbl  = mode_req(mode3, order_fwd, chan_sel);
        end else begin
            lbl = "R5";
        end
        m_rs_prev = rs;
        @(posedge clk);
        @(negedge clk);
        chk(lbl, ch_idx, m_ch);
        chk("R9 valid", tag_valid, a);
        if (a) chk("R9 tag", tag, tag_exp);
    endtask

    // Watch int_pulse for n slots; expect it only at slot exp_at (0 = never).
    task automatic watch(input int n, input int exp_at, input string req);
        int hit   = 0;
        int stray = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (int_pulse === 1'b1) begin
                if (i == exp_at) hit++;
                else             stray++;
            end
        end
        chk({req, " pulse at due slot"}, hit, (exp_at > 0) ? 1 : 0);
        chk({req, " no stray pulse"}, stray, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        adv        = 1'b0;
        restart_in = 1'b0;
        mode3      = 1'b1;
        order_fwd  = 1'b1;
        chan_sel   = 3'b001;
        alt_fmt    = 1'b0;
        pulse_in   = 1'b0;
        edge_pos   = 1'b1;
        dly_code   = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ch_idx", ch_idx, 0);
        chk("R1 tag_valid", tag_valid, 0);
        chk("R1 int_pulse", int_pulse, 0);
        rst_n     = 1'b1;
        m_ch      = 0;
        m_rs_prev = 1'b0;

        // Sweep of mode, order and all select patterns (R2 to R9).
        for (int m = 1; m >= 0; m--) begin
            for (int o = 0; o < 2; o++) begin
                for (int s = 0; s < 8; s++) begin
                    mode3     = m[0];
                    order_fwd = o[0];
                    chan_sel  = s[2:0];
                    for (int k = 0; k < 9; k++) begin
                        slot((k % 3) != 2, (k == 4) || (k == 5));
                    end
                end
            end
        end

        // R10: every delay code, both edge choices.
        alt_fmt = 1'b1;
        for (int ep = 0; ep < 2; ep++) begin
            for (int code = 0; code < 8; code++) begin
                edge_pos = ep[0];
                dly_code = code[2:0];
                pulse_in = ep[0] ? 1'b0 : 1'b1;
                watch(10, 0, "R10 opposite edge");
                pulse_in = ep[0] ? 1'b1 : 1'b0;
                watch(10, code + 1, "R10");
            end
        end

        // R11: generator disabled, edges of both kinds ignored.
        alt_fmt  = 1'b0;
        dly_code = 3'd2;
        watch(10, 0, "R11 flush");
        for (int ep = 0; ep < 2; ep++) begin
            edge_pos = ep[0];
            pulse_in = ~pulse_in;
            watch(10, 0, "R11");
            pulse_in = ~pulse_in;
            watch(10, 0, "R11");
        end

        finish_run();
    end

endmodule